// File: doc/BRIEF.md
# Leaf Page Permission and Access-Tracking Checker

This block judges one memory access against a leaf page-table entry. It takes the 64-bit entry, the kind of access (data read, data write or instruction fetch) and whether the requester runs at user or supervisor level. It returns an allow or fault decision with a coded cause. It also returns a copy of the entry in which the tracking bit for that access kind has been set. A writeback flag goes high when the copy differs from the entry and must be stored back. The page memory type is passed through for downstream ordering and caching decisions.

The permission model is strict. Read, write and execute are granted by three independent bits, so execute-only and write-without-read pages are legal. A single owner bit gives a page to exactly one privilege level. Each access kind has its own tracking bit. The decision is combinational. A parameter selects whether the results are registered for one cycle before they reach the outputs. The block does not walk page tables and does not touch memory.

Top module: `pte_guard`

## Requirements
- R1: A read is allowed only with bit 1 set, a write only with bit 2 set, and a fetch only with bit 3 set. The three bits are independent: a page with only bit 3 set permits fetches, and a read or write to it faults with cause 3.
- R2: An allowed access returns the entry with only its own tracking bit set: bit 5 for a read (kind 0), bit 6 for a write (kind 1), bit 7 for a fetch (kind 2). Every other bit is unchanged. A faulting access returns the entry unchanged.
- R3: Bit 4 set marks a user page and bit 4 clear marks a supervisor page. An access whose privilege input differs from bit 4 faults with cause 2, in both directions.
- R4: type_o always equals entry bits 9:8, with the encoding 0 RAM, 1 framebuffer, 2 memory-mapped I/O, 3 page-table page.
- R5: An entry with bit 0 (valid) clear always faults with cause 1.
- R6: An entry with either reserved bit 11:10 set is malformed and faults with cause 4.
- R7: A fetch from a page of type 2 or 3 faults with cause 4 even when bit 3 is set. Reads and writes to these types are judged only by their permission bits.
- R8: The cause codes are 0 none, 1 invalid, 2 privilege, 3 permission and 4 malformed or type. When several faults apply, the highest-priority one is reported, in this order: invalid, then malformed (reserved bits or access kind 3), then privilege, then fetch type, then permission. fault_o is the inverse of allow_o.
- R9: wb_o is high only when the access is allowed and its tracking bit was clear in the input entry.
- R10: With REG_OUT=1, each result appears one clock after its inputs. While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pte_i | input | 64 | Leaf page-table entry |
| kind_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 illegal |
| user_i | input | 1 | 1 = user-level requester, 0 = supervisor |
| allow_o | output | 1 | Access permitted |
| fault_o | output | 1 | Access refused |
| cause_o | output | 3 | Fault cause code |
| pte_o | output | 64 | Entry with the matching tracking bit set |
| wb_o | output | 1 | Updated entry must be written back |
| type_o | output | 2 | Page memory type |

## Verification
On every cycle, the assertions check the following against the inputs aligned to the output latency:
- allow_o and fault_o are complementary.
- An allowed access matches the owner bit and, for a fetch, has execute permission.
- An invalid entry reports cause 1.
- The output entry differs from the input only in one tracking bit.
- wb_o implies a real change.
- type_o follows bits 9:8.

Only the bench's scenarios show:
- the exact cause chosen when several faults overlap;
- the execute-only and memory-type fetch cases;
- the one-cycle latency and zeroed reset state.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;
  localparam int unsigned PTE_W     = 64;
  localparam int unsigned B_VALID   = 0;
  localparam int unsigned B_CAN_R   = 1;
  localparam int unsigned B_CAN_W   = 2;
  localparam int unsigned B_CAN_X   = 3;
  localparam int unsigned B_USER    = 4;
  localparam int unsigned B_DID_R   = 5;
  localparam int unsigned B_DID_W   = 6;
  localparam int unsigned B_DID_X   = 7;
  localparam int unsigned B_TYPE_LO = 8;
  localparam int unsigned B_RSV_LO  = 10;
  localparam int unsigned CAUSE_W   = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    MT_RAM  = 2'd0,
    MT_FB   = 2'd1,
    MT_MMIO = 2'd2,
    MT_PTAB = 2'd3
  } mtype_e;

  typedef enum logic [CAUSE_W-1:0] {
    FC_NONE  = 3'd0,
    FC_INVAL = 3'd1,
    FC_PRIV  = 3'd2,
    FC_PERM  = 3'd3,
    FC_MALF  = 3'd4
  } cause_e;

  typedef struct packed {
    logic       valid;
    logic [2:0] can;   // {x, w, r}
    logic       user;
    logic [2:0] did;   // {x, w, r}
    mtype_e     mtype;
    logic [1:0] rsv;
  } pte_flags_t;
endpackage

// File: rtl/pte_field_decode.sv
module pte_field_decode
  import pte_chk_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  output pte_flags_t       flags_o
);
  always_comb begin
    flags_o.valid = pte_i[B_VALID];
    flags_o.can   = {pte_i[B_CAN_X], pte_i[B_CAN_W], pte_i[B_CAN_R]};
    flags_o.user  = pte_i[B_USER];
    flags_o.did   = {pte_i[B_DID_X], pte_i[B_DID_W], pte_i[B_DID_R]};
    flags_o.mtype = mtype_e'(pte_i[B_TYPE_LO +: 2]);
    flags_o.rsv   = pte_i[B_RSV_LO +: 2];
  end
endmodule

// File: rtl/pte_rule_eval.sv
module pte_rule_eval
  import pte_chk_pkg::*;
(
  input  pte_flags_t flags_i,
  input  logic [1:0] kind_i,
  input  logic       user_i,
  output cause_e     cause_o,
  output logic [2:0] sel_o
);
  logic need_ok;
  logic exec_type_bad;

  always_comb begin
    sel_o = 3'b000;
    unique case (acc_e'(kind_i))
      ACC_READ:  sel_o = 3'b001;
      ACC_WRITE: sel_o = 3'b010;
      ACC_FETCH: sel_o = 3'b100;
      default:   sel_o = 3'b000;
    endcase
  end

  assign need_ok       = |(sel_o & flags_i.can);
  assign exec_type_bad = (acc_e'(kind_i) == ACC_FETCH) &&
                         (flags_i.mtype == MT_MMIO || flags_i.mtype == MT_PTAB);

  // fixed priority: invalid > malformed > privilege > fetch type > permission
  always_comb begin
    if (!flags_i.valid)                             cause_o = FC_INVAL;
    else if (|flags_i.rsv || kind_i == ACC_BAD)     cause_o = FC_MALF;
    else if (flags_i.user != user_i)                cause_o = FC_PRIV;
    else if (exec_type_bad)                         cause_o = FC_MALF;
    else if (!need_ok)                              cause_o = FC_PERM;
    else                                            cause_o = FC_NONE;
  end
endmodule

// File: rtl/pte_track_update.sv
module pte_track_update
  import pte_chk_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic [2:0]       sel_i,
  input  logic             allow_i,
  output logic [PTE_W-1:0] pte_o,
  output logic             wb_o
);
  logic [2:0] did_old;
  logic [2:0] did_new;

  assign did_old = {pte_i[B_DID_X], pte_i[B_DID_W], pte_i[B_DID_R]};
  assign did_new = allow_i ? (did_old | sel_i) : did_old;

  always_comb begin
    pte_o          = pte_i;
    pte_o[B_DID_R] = did_new[0];
    pte_o[B_DID_W] = did_new[1];
    pte_o[B_DID_X] = did_new[2];
  end

  assign wb_o = allow_i && |(sel_i & ~did_old);
endmodule

// File: rtl/pte_guard.sv
module pte_guard
  import pte_chk_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PTE_W-1:0]   pte_i,
  input  logic [1:0]         kind_i,
  input  logic               user_i,
  output logic               allow_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PTE_W-1:0]   pte_o,
  output logic               wb_o,
  output logic [1:0]         type_o
);
  pte_flags_t       flags;
  cause_e           cause_c;
  logic [2:0]       sel;
  logic             allow_c;
  logic [PTE_W-1:0] pte_c;
  logic             wb_c;

  pte_field_decode u_dec (
    .pte_i   (pte_i),
    .flags_o (flags)
  );

  pte_rule_eval u_eval (
    .flags_i (flags),
    .kind_i  (kind_i),
    .user_i  (user_i),
    .cause_o (cause_c),
    .sel_o   (sel)
  );

  assign allow_c = (cause_c == FC_NONE);

  pte_track_update u_upd (
    .pte_i   (pte_i),
    .sel_i   (sel),
    .allow_i (allow_c),
    .pte_o   (pte_c),
    .wb_o    (wb_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          allow_o <= 1'b0;
          fault_o <= 1'b0;
          cause_o <= '0;
          pte_o   <= '0;
          wb_o    <= 1'b0;
          type_o  <= '0;
        end else begin
          allow_o <= allow_c;
          fault_o <= !allow_c;
          cause_o <= cause_c;
          pte_o   <= pte_c;
          wb_o    <= wb_c;
          type_o  <= flags.mtype;
        end
      end
    end else begin : g_comb
      always_comb begin
        allow_o = rst_ni && allow_c;
        fault_o = rst_ni && !allow_c;
        cause_o = rst_ni ? cause_c : '0;
        pte_o   = rst_ni ? pte_c : '0;
        wb_o    = rst_ni && wb_c;
        type_o  = rst_ni ? flags.mtype : MT_RAM;
      end
    end
  endgenerate
endmodule

// File: rtl/pte_guard_chk.sv
module pte_guard_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] pte_i,
  input logic [1:0]  kind_i,
  input logic        user_i,
  input logic        allow_o,
  input logic        fault_o,
  input logic [2:0]  cause_o,
  input logic [63:0] pte_o,
  input logic        wb_o,
  input logic [1:0]  type_o
);
  logic [63:0] pte_d;
  logic [1:0]  kind_d;
  logic        user_d;
  logic        live;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pte_d <= '0; kind_d <= '0; user_d <= 1'b0; live <= 1'b0;
        end else begin
          pte_d <= pte_i; kind_d <= kind_i; user_d <= user_i; live <= 1'b1;
        end
      end
    end else begin : g_now
      assign pte_d  = pte_i;
      assign kind_d = kind_i;
      assign user_d = user_i;
      assign live   = 1'b1;
    end
  endgenerate

  AST_FLAG_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> (fault_o != allow_o)); // R8
  AST_EXEC_NEEDS_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && allow_o && kind_d == 2'd2) |-> pte_d[3]); // R1
  AST_ONE_TRACK_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && allow_o) |-> (((pte_o ^ pte_d) & ~64'hE0) == 64'd0 &&
                           $countones(pte_o ^ pte_d) <= 1)); // R2
  AST_FAULT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && fault_o) |-> (pte_o == pte_d)); // R2
  AST_OWNER_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && allow_o) |-> (pte_d[4] == user_d)); // R3
  AST_TYPE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> (type_o == pte_d[9:8])); // R4
  AST_INVALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !pte_d[0]) |-> (fault_o && cause_o == 3'd1)); // R5
  AST_WB_REAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> (allow_o && pte_o != pte_d)); // R9
endmodule

bind pte_guard pte_guard_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pte_i(pte_i), .kind_i(kind_i),
  .user_i(user_i), .allow_o(allow_o), .fault_o(fault_o), .cause_o(cause_o),
  .pte_o(pte_o), .wb_o(wb_o), .type_o(type_o)
);

// File: tb/sim_pte_guard.sv
`timescale 1ns/1ps
module sim_pte_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] pte_i = '0;
  logic [1:0]  kind_i = '0;
  logic        user_i = 1'b0;
  logic        allow_o, fault_o, wb_o;
  logic [2:0]  cause_o;
  logic [63:0] pte_o;
  logic [1:0]  type_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic        allow;
    logic [2:0]  cause;
    logic [63:0] pte;
    logic        wb;
    logic [1:0]  mtype;
    string       req;
  } exp_t;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  pte_guard #(.REG_OUT(1'b1)) u0 (
    .clk_i, .rst_ni, .pte_i, .kind_i, .user_i,
    .allow_o, .fault_o, .cause_o, .pte_o, .wb_o, .type_o
  );

  function automatic exp_t model(logic [63:0] p, logic [1:0] k, logic u, string req);
    exp_t e;
    logic [2:0] need;
    int didb;
    need = (k == 2'd0) ? 3'b001 : (k == 2'd1) ? 3'b010 : (k == 2'd2) ? 3'b100 : 3'b000;
    if (!p[0])                                      e.cause = 3'd1; // R5
    else if (p[11:10] != 2'b00 || k == 2'd3)        e.cause = 3'd4; // R6
    else if (p[4] != u)                             e.cause = 3'd2; // R3
    else if (k == 2'd2 && p[9])                     e.cause = 3'd4; // R7
    else if ((need & {p[3], p[2], p[1]}) == 3'b000) e.cause = 3'd3; // R1
    else                                            e.cause = 3'd0;
    e.allow = (e.cause == 3'd0);
    e.pte   = p;
    e.wb    = 1'b0;
    if (e.allow) begin
      didb = 5 + int'(k);
      e.wb = !p[didb];
      e.pte[didb] = 1'b1;
    end
    e.mtype = p[9:8];
    e.req   = req;
    return e;
  endfunction

  task automatic apply(logic [63:0] p, logic [1:0] k, logic u, string req);
    @(negedge clk_i);
    pte_i = p; kind_i = k; user_i = u;
    q.push_back(model(p, k, u, req));
  endtask

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp_v, string what);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  // monitor: one cycle of latency (R10)
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (rst_ni && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, 128'(allow_o), 128'(e.allow), "allow");
        chk("R8", 128'(fault_o), 128'(!e.allow), "fault");
        chk(e.req, 128'(cause_o), 128'(e.cause), "cause");
        chk(e.req, 128'(pte_o), 128'(e.pte), "pte");
        chk("R9", 128'(wb_o), 128'(e.wb), "wb");
        chk("R4", 128'(type_o), 128'(e.mtype), "type");
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] fr;
    logic [63:0] x;
    fr = 64'hABCD_1234_5000;
    pte_i = 64'hFFFF_FFFF_FFFF_FFFF; kind_i = 2'd1; user_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10", 128'({allow_o, fault_o, cause_o, wb_o, type_o}), 128'(0), "reset flags");
    chk("R10", 128'(pte_o), 128'(0), "reset pte");
    rst_ni = 1'b1;
    // R1 / R2 / R9 basic accesses on RAM
    apply(fr | 64'h07, 2'd0, 1'b0, "R2");            // read rw page, sets bit5, wb
    apply(fr | 64'h27, 2'd0, 1'b0, "R9");            // did-read already set, no wb
    apply(fr | 64'h07, 2'd1, 1'b0, "R2");            // write sets bit6
    apply(fr | 64'h09, 2'd2, 1'b0, "R1");            // execute-only fetch allowed
    apply(fr | 64'h09, 2'd0, 1'b0, "R1");            // execute-only read -> 3
    apply(fr | 64'h09, 2'd1, 1'b0, "R1");            // execute-only write -> 3
    apply(fr | 64'h05, 2'd1, 1'b0, "R1");            // write-only write ok
    apply(fr | 64'h03, 2'd1, 1'b0, "R1");            // read-only write -> 3
    // R3 owner bit
    apply(fr | 64'h1F, 2'd0, 1'b0, "R3");            // supervisor on user page
    apply(fr | 64'h0F, 2'd0, 1'b1, "R3");            // user on supervisor page
    apply(fr | 64'h1F, 2'd2, 1'b1, "R3");            // user on user page ok
    // R5 invalid, highest priority
    apply(fr | 64'hC1E, 2'd3, 1'b1, "R5");
    // R6 reserved bits
    apply(fr | 64'h40F, 2'd0, 1'b0, "R6");
    apply(fr | 64'h81F, 2'd0, 1'b0, "R6");           // beats privilege mismatch
    // R7 fetch type
    apply(fr | 64'h20F, 2'd2, 1'b0, "R7");           // MMIO fetch -> 4
    apply(fr | 64'h30F, 2'd2, 1'b0, "R7");           // page-table fetch -> 4
    apply(fr | 64'h10F, 2'd2, 1'b0, "R7");           // framebuffer fetch ok
    apply(fr | 64'h203, 2'd0, 1'b0, "R7");           // MMIO read ok
    apply(fr | 64'h301, 2'd2, 1'b1, "R8");           // privilege beats type
    apply(fr | 64'h20B, 2'd2, 1'b0, "R8");           // type beats permission check path
    // R8 illegal kind
    apply(fr | 64'h0F, 2'd3, 1'b0, "R8");
    // R4 all types pass through
    for (int t = 0; t < 4; t++) apply(fr | (64'(t) << 8) | 64'h07, 2'd0, 1'b0, "R4");
    // R2 all did bits already set
    apply(fr | 64'hEF, 2'd2, 1'b0, "R9");
    // pseudo-random sweep over low bits
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 200; i++) begin
      x ^= x << 13; x ^= x >> 7; x ^= x << 17;
      apply({x[63:12], x[11:10] & {2{x[40] & x[41]}}, x[9:0] | {9'd0, x[42] | x[43]}},
            x[45:44], x[46], "R8");
    end
    // R10 latency: hold then drain
    @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10", 128'(q.size()), 128'(0), "queue drained");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule